// File: doc/BRIEF.md
# Spread-Spectrum Switching Clock Dither

This block produces the switching-cycle timing for a switched-mode power stage. It runs from a fast system clock. Each switching cycle it emits one boundary pulse and a high-phase output whose length tracks a commanded duty ratio. The nominal cycle length is programmable in system clocks. When dithering is allowed, every cycle's length is moved away from the nominal by the sum of two offsets. The first is a slow triangular sweep whose step size is re-drawn at random each time the sweep turns round, so its repetition rate keeps wandering. The second is a fast pseudo-random term that changes every cycle. Together they spread the emission energy over a wide band.

The on-time of every cycle is recomputed from that cycle's own dithered length, so the high fraction stays close to the commanded ratio even while the length moves. Length and on-time are captured together at each boundary. An external-sync flag overrides the enable and forces plain nominal cycles. Turning dithering off also empties the triangle state, so the next cycle is exactly nominal.

Top module: `spread_clk_dither`

## Requirements
- R1: While rst_n is low, cycle_start, pwm_high and cur_on_time read 0 and cur_period reads 1.
- R2: The first cycle_start pulse comes one clock after reset release. Thereafter each cycle_start is a one-clock pulse, and consecutive pulses are exactly cur_period clocks apart, where cur_period is the value shown during the pulse.
- R3: When dither_en is 0 at a cycle boundary, the cycle that starts has length nom_period.
- R4: When ext_sync is 1 at a cycle boundary, the cycle that starts has length nom_period, whatever dither_en is.
- R5: When dithering is active at a boundary, the new length is nom_period + tri + rnd before saturation. rnd is the low RND_BITS bits of a 16-bit LFSR, read as two's complement. The LFSR resets to LFSR_SEED and shifts left with new bit0 = b15^b13^b12^b10, once per active boundary, after its value has been used.
- R6: tri starts at 0 going up with step 1, and moves by its step at each active boundary, after its value has been used. If a move would reach or pass +TRI_AMP or -TRI_AMP, tri is clamped to that limit, the direction reverses, and the new step becomes LFSR bits [15:14] + 1 (1 to 4), taken before the shift.
- R7: The dithered length is saturated to the range floor(nom/2) to nom + floor(nom/2).
- R8: cur_on_time = floor(duty_num × cur_period / 256). pwm_high is 1 during the first cur_on_time clocks of each cycle, counting the clock of cycle_start.
- R9: cur_period and cur_on_time change only in the clock where cycle_start is 1.
- R10: Whenever dithering is inactive (dither_en 0 or ext_sync 1) during a clock, tri returns to 0 with direction up and step 1. The LFSR holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dither_en | input | 1 | Allows the frequency dither |
| ext_sync | input | 1 | External sync present; forces nominal cycles |
| nom_period | input | PER_W | Nominal cycle length in clocks |
| duty_num | input | DUTY_W | Duty ratio numerator over 2^DUTY_W |
| cycle_start | output | 1 | One-clock pulse at each cycle boundary |
| pwm_high | output | 1 | High phase of the current cycle |
| cur_period | output | PER_W+1 | Length of the current cycle |
| cur_on_time | output | PER_W+1 | On-time of the current cycle |

## Verification
The assertions take nom_period to be at least 4. This keeps the lower saturation bound at 2 or more, so two boundaries never fall in adjacent clocks, and it keeps the upper bound within the width of cur_period. The duty numerator is taken to be below 256, so the on-time can never exceed the length. The stimulus holds nom_period between 4 and 1000 and changes the inputs only on the falling clock edge. It includes stretches where the nominal is small enough for the triangle to drive the length into both saturation limits, and a stretch where the sync flag toggles in the middle of cycles.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
   typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DN = 1'b1} sweep_dir_e;

   localparam int LFSR_W = 16;

   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction
endpackage

// File: rtl/ssd_lfsr.sv
module ssd_lfsr
   import ssd_pkg::*;
#(
   parameter logic [15:0] SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [LFSR_W-1:0] state
);
   logic [LFSR_W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= SEED;
      else if (adv) state_q <= lfsr_step(state_q);
   end

   assign state = state_q;

   // R5
   lfsr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> state_q[15:1] == $past(state_q[14:0]));

   // R10
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state_q));
endmodule

// File: rtl/ssd_tri.sv
module ssd_tri
   import ssd_pkg::*;
#(
   parameter int OW      = 13,
   parameter int TRI_AMP = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 step_en,
   input  logic [1:0]           rnd2,
   output logic signed [OW-1:0] tri_off
);
   generate
      if (TRI_AMP == 0) begin : g_no_tri
         assign tri_off = '0;
      end else begin : g_tri
         localparam logic signed [OW-1:0] AMP_P = OW'(TRI_AMP);
         localparam logic signed [OW-1:0] AMP_N = -AMP_P;

         sweep_dir_e          dir_q;
         logic [2:0]          step_q;
         logic signed [OW-1:0] tri_q;
         logic signed [OW-1:0] step_s;
         logic signed [OW-1:0] up_v;
         logic signed [OW-1:0] dn_v;
         logic [2:0]          new_step;

         assign step_s   = $signed({{(OW-3){1'b0}}, step_q});
         assign up_v     = tri_q + step_s;
         assign dn_v     = tri_q - step_s;
         assign new_step = {1'b0, rnd2} + 3'd1;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tri_q  <= '0;
               dir_q  <= SWEEP_UP;
               step_q <= 3'd1;
            end else if (clr) begin
               tri_q  <= '0;
               dir_q  <= SWEEP_UP;
               step_q <= 3'd1;
            end else if (step_en) begin
               if (dir_q == SWEEP_UP) begin
                  if (up_v >= AMP_P) begin
                     tri_q  <= AMP_P;
                     dir_q  <= SWEEP_DN;
                     step_q <= new_step;
                  end else begin
                     tri_q <= up_v;
                  end
               end else begin
                  if (dn_v <= AMP_N) begin
                     tri_q  <= AMP_N;
                     dir_q  <= SWEEP_UP;
                     step_q <= new_step;
                  end else begin
                     tri_q <= dn_v;
                  end
               end
            end
         end

         assign tri_off = tri_q;

         // R6
         tri_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tri_q >= AMP_N && tri_q <= AMP_P);

         // R6
         tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step_q >= 3'd1 && step_q <= 3'd4);

         // R10
         tri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> tri_q == '0 && dir_q == SWEEP_UP);
      end
   endgenerate
endmodule

// File: rtl/ssd_period_calc.sv
module ssd_period_calc #(
   parameter int PER_W    = 10,
   parameter int DUTY_W   = 8,
   parameter int RND_BITS = 4,
   parameter int OW       = PER_W + 3,
   parameter int RB_IN    = (RND_BITS > 0) ? RND_BITS : 1
) (
   input  logic [PER_W-1:0]     nom,
   input  logic [DUTY_W-1:0]    duty,
   input  logic                 act,
   input  logic signed [OW-1:0] tri_off,
   input  logic [RB_IN-1:0]     rnd_src,
   output logic [PER_W:0]       period_nxt,
   output logic [PER_W:0]       on_nxt
);
   localparam int PW = PER_W + 1;

   logic signed [OW-1:0] rnd_off;
   logic signed [OW-1:0] nom_s;
   logic signed [OW-1:0] lo_s;
   logic signed [OW-1:0] hi_s;
   logic signed [OW-1:0] sum_s;
   logic signed [OW-1:0] sat_s;
   logic [DUTY_W+PW-1:0] prod;

   generate
      if (RND_BITS == 0) begin : g_no_rnd
         assign rnd_off = '0;
      end else begin : g_rnd
         assign rnd_off = $signed({{(OW-RND_BITS){rnd_src[RND_BITS-1]}}, rnd_src});
      end
   endgenerate

   always_comb begin
      nom_s = $signed({3'b000, nom});
      lo_s  = nom_s >>> 1;
      hi_s  = nom_s + lo_s;
      sum_s = nom_s + (act ? (tri_off + rnd_off) : '0);
      if (sum_s < lo_s)      sat_s = lo_s;
      else if (sum_s > hi_s) sat_s = hi_s;
      else                   sat_s = sum_s;
      period_nxt = sat_s[PW-1:0];
      prod       = {{PW{1'b0}}, duty} * {{DUTY_W{1'b0}}, period_nxt};
      on_nxt     = prod[DUTY_W +: PW];
   end
endmodule

// File: rtl/spread_clk_dither.sv
module spread_clk_dither
   import ssd_pkg::*;
#(
   parameter int          PER_W     = 10,
   parameter int          DUTY_W    = 8,
   parameter int          RND_BITS  = 4,
   parameter int          TRI_AMP   = 24,
   parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dither_en,
   input  logic              ext_sync,
   input  logic [PER_W-1:0]  nom_period,
   input  logic [DUTY_W-1:0] duty_num,
   output logic              cycle_start,
   output logic              pwm_high,
   output logic [PER_W:0]    cur_period,
   output logic [PER_W:0]    cur_on_time
);
   localparam int PW    = PER_W + 1;
   localparam int OW    = PER_W + 3;
   localparam int RB_IN = (RND_BITS > 0) ? RND_BITS : 1;

   generate
      if (PER_W < 4 || PER_W > 20) begin : g_bad_per
         $error("PER_W out of supported range");
      end
      if (RND_BITS < 0 || RND_BITS > 14) begin : g_bad_rnd
         $error("RND_BITS out of supported range");
      end
      if (TRI_AMP < 0 || TRI_AMP >= (1 << (PER_W - 1))) begin : g_bad_tri
         $error("TRI_AMP out of supported range");
      end
      if (DUTY_W < 1 || DUTY_W > 16) begin : g_bad_duty
         $error("DUTY_W out of supported range");
      end
   endgenerate

   logic                 act;
   logic                 wrap;
   logic [PW-1:0]        cnt_q;
   logic [PW-1:0]        per_q;
   logic [PW-1:0]        on_q;
   logic                 cs_q;
   logic [LFSR_W-1:0]    lfsr;
   logic signed [OW-1:0] tri_off;
   logic [PW-1:0]        period_nxt;
   logic [PW-1:0]        on_nxt;

   assign act  = dither_en & ~ext_sync;
   assign wrap = ({1'b0, cnt_q} + {{PW{1'b0}}, 1'b1}) >= {1'b0, per_q};

   ssd_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wrap & act),
      .state (lfsr)
   );

   ssd_tri #(.OW(OW), .TRI_AMP(TRI_AMP)) u_tri (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (~act),
      .step_en (wrap & act),
      .rnd2    (lfsr[15:14]),
      .tri_off (tri_off)
   );

   ssd_period_calc #(
      .PER_W(PER_W), .DUTY_W(DUTY_W), .RND_BITS(RND_BITS), .OW(OW), .RB_IN(RB_IN)
   ) u_calc (
      .nom        (nom_period),
      .duty       (duty_num),
      .act        (act),
      .tri_off    (tri_off),
      .rnd_src    (lfsr[RB_IN-1:0]),
      .period_nxt (period_nxt),
      .on_nxt     (on_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= PW'(1);
         on_q  <= '0;
         cs_q  <= 1'b0;
      end else begin
         cs_q <= wrap;
         if (wrap) begin
            cnt_q <= '0;
            per_q <= period_nxt;
            on_q  <= on_nxt;
         end else begin
            cnt_q <= cnt_q + PW'(1);
         end
      end
   end

   assign cycle_start = cs_q;
   assign pwm_high    = cnt_q < on_q;
   assign cur_period  = per_q;
   assign cur_on_time = on_q;

   logic [PW-1:0] nom_ext;
   logic [PW-1:0] nom_lo;
   logic [PW-1:0] nom_hi;
   assign nom_ext = {1'b0, nom_period};
   assign nom_lo  = {2'b00, nom_period[PER_W-1:1]};
   assign nom_hi  = nom_ext + nom_lo;

   // R7
   period_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |-> cur_period >= $past(nom_lo) && cur_period <= $past(nom_hi));

   // R3 R4
   nominal_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_start && !$past(act)) |-> cur_period == $past(nom_ext));

   // R9
   period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_start |-> ($stable(cur_period) && $stable(cur_on_time)));

   // R8
   on_le_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_on_time <= cur_period);

   // R5
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);
endmodule

// File: tb/spread_clk_dither_tb_top.sv
module spread_clk_dither_tb_top;
   localparam int          PER_W    = 10;
   localparam int          DUTY_W   = 8;
   localparam int          RND_BITS = 4;
   localparam int          TRI_AMP  = 24;
   localparam logic [15:0] SEED     = 16'hACE1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dither_en = 1'b0;
   logic              ext_sync = 1'b0;
   logic [PER_W-1:0]  nom_period = 10'd50;
   logic [DUTY_W-1:0] duty_num = 8'd128;
   logic              cycle_start;
   logic              pwm_high;
   logic [PER_W:0]    cur_period;
   logic [PER_W:0]    cur_on_time;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   string req_tag = "R3";

   always #10 clk = ~clk;

   spread_clk_dither #(
      .PER_W(PER_W), .DUTY_W(DUTY_W), .RND_BITS(RND_BITS),
      .TRI_AMP(TRI_AMP), .LFSR_SEED(SEED)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .dither_en(dither_en), .ext_sync(ext_sync),
      .nom_period(nom_period), .duty_num(duty_num),
      .cycle_start(cycle_start), .pwm_high(pwm_high),
      .cur_period(cur_period), .cur_on_time(cur_on_time)
   );

   // behavioural reference model
   int m_cnt, m_per, m_on, m_tri, m_step;
   bit m_cs, m_up;
   logic [15:0] m_lfsr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 1; m_on = 0; m_cs = 0;
         m_tri = 0; m_up = 1; m_step = 1; m_lfsr = SEED;
      end else begin
         bit act;
         act = dither_en && !ext_sync;
         if (m_cnt + 1 >= m_per) begin
            int p;
            p = nom_period;
            if (act) begin
               int r, lo, hi;
               r = m_lfsr & ((1 << RND_BITS) - 1);
               if (r >= (1 << (RND_BITS - 1))) r = r - (1 << RND_BITS);
               lo = nom_period / 2;
               hi = nom_period + lo;
               p = nom_period + m_tri + r;
               if (p < lo) p = lo;
               if (p > hi) p = hi;
            end
            m_per = p;
            m_on = (duty_num * p) / 256;
            m_cnt = 0;
            m_cs = 1;
            if (act) begin
               int ns;
               ns = m_lfsr[15:14] + 1;
               if (m_up) begin
                  if (m_tri + m_step >= TRI_AMP) begin
                     m_tri = TRI_AMP; m_up = 0; m_step = ns;
                  end else m_tri = m_tri + m_step;
               end else begin
                  if (m_tri - m_step <= -TRI_AMP) begin
                     m_tri = -TRI_AMP; m_up = 1; m_step = ns;
                  end else m_tri = m_tri - m_step;
               end
               m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            end
         end else begin
            m_cnt = m_cnt + 1;
            m_cs = 0;
         end
         if (!act) begin
            m_tri = 0; m_up = 1; m_step = 1;
         end
      end
   end

   task automatic check(input string req, input string what, input int act_v, input int exp_v);
      compared++;
      if (act_v != exp_v) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
      end
   endtask

   // per-clock comparison, away from the active edge
   int prev_per = 1;
   int prev_on = 0;
   int min_p = 100000;
   int max_p = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2", "cycle_start", int'(cycle_start), int'(m_cs));
         check("R8", "pwm_high", int'(pwm_high), int'(m_cnt < m_on));
         check("R8", "cur_on_time", int'(cur_on_time), m_on);
         check(req_tag, "cur_period", int'(cur_period), m_per);
         if (!cycle_start) begin
            check("R9", "period held", int'(cur_period), prev_per);
            check("R9", "on-time held", int'(cur_on_time), prev_on);
         end else begin
            if (int'(cur_period) < min_p) min_p = int'(cur_period);
            if (int'(cur_period) > max_p) max_p = int'(cur_period);
         end
         prev_per = int'(cur_period);
         prev_on = int'(cur_on_time);
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      run(3);
      check("R1", "cycle_start in reset", int'(cycle_start), 0);
      check("R1", "pwm_high in reset", int'(pwm_high), 0);
      check("R1", "cur_on_time in reset", int'(cur_on_time), 0);
      check("R1", "cur_period in reset", int'(cur_period), 1);

      // R3: dither disabled
      req_tag = "R3";
      rst_n = 1'b1;
      run(1);
      check("R2", "first pulse after release", int'(cycle_start), 1);
      run(400);
      check("R3", "period with dither off", int'(cur_period), 50);

      // R5 R6: long dithered run, triangle reversals
      req_tag = "R5 R6";
      dither_en = 1'b1; nom_period = 10'd40; duty_num = 8'd100;
      min_p = 100000; max_p = 0;
      run(12000);
      check("R6", "sweep reached high side", int'(max_p > 40 + TRI_AMP - 8), 1);
      check("R6", "sweep reached low side", int'(min_p < 40 - TRI_AMP + 8), 1);

      // R4: sync forces nominal
      req_tag = "R4";
      ext_sync = 1'b1;
      run(200);
      min_p = 100000; max_p = 0;
      run(400);
      check("R4", "min period under sync", min_p, 40);
      check("R4", "max period under sync", max_p, 40);

      // R10: resume, triangle restarted from zero
      req_tag = "R10 R5";
      ext_sync = 1'b0;
      run(3000);
      dither_en = 1'b0;
      req_tag = "R10";
      run(150);
      dither_en = 1'b1;
      run(2000);

      // R7: small nominal, both saturation limits
      req_tag = "R7";
      nom_period = 10'd8; duty_num = 8'd255;
      run(100);
      min_p = 100000; max_p = 0;
      run(3000);
      check("R7", "lower saturation", min_p, 4);
      check("R7", "upper saturation", max_p, 12);

      // R8: duty extremes at large nominal
      req_tag = "R8 R7";
      nom_period = 10'd1000; duty_num = 8'd0;
      run(3000);
      duty_num = 8'd255;
      run(3000);
      duty_num = 8'd1;
      run(2000);

      // R4: sync toggling mid-cycle at minimum nominal
      req_tag = "R4 R10";
      nom_period = 10'd4; duty_num = 8'd64;
      for (int i = 0; i < 80; i++) begin
         ext_sync = ~ext_sync;
         run(7);
      end
      ext_sync = 1'b0;
      run(500);

      finish_run();
   end
endmodule